// File: doc/BRIEF.md
# Stereo Record-Then-Playback Sequencer

This block sits between a two-slot stereo audio serial port and a word-addressed sample memory. It captures one stereo pair for each audio frame into consecutive memory words, starting at a base address. Once the write address has climbed to a limit, it rewinds to the base address. It then drains the same words back out, one pair per frame, into the left and right transmit slots. During playback, the two remaining transmit slots carry a fixed control word. When the read address reaches the limit, the sequencer stops in a terminal state that only a reset leaves.

The frame pace comes from a frame-active flag. A frame counts only when the flag has been seen low and is then seen high. All memory traffic for a frame falls in the two clock cycles that follow the accepted edge. The memory port is synchronous, and read data arrives one cycle after the request. The base address, the limit and the control word are parameters.

Top module: `stereo_rec_play`

## Requirements
- R1: While reset is held and just after it is released, `done` is low, all four transmit slots read zero, and neither `memWe` nor `memRe` is asserted.
- R2: A frame step is taken only when `frameActive` is sampled low on one rising clock edge and high on the next. A flag held high through reset release causes no step. A flag held high for many cycles causes exactly one step.
- R3: In record, each accepted edge latches `rxLeft` and `rxRight`. The cycle after the edge writes the left sample at the current address. The following cycle writes the right sample at that address plus one. Addresses start at `START_ADDR` and rise by two per frame.
- R4: Once the address is no longer below `LIMIT_ADDR`, recording ends after exactly (LIMIT_ADDR-START_ADDR)/2 frames, the address rewinds to `START_ADDR`, and no access ever falls outside [START_ADDR, LIMIT_ADDR).
- R5: In playback, the cycle after an accepted edge requests the left word and the next cycle requests the right word, in the same address order as recording. Read data is taken one cycle after its request, so `txLeft` changes two edges after the frame edge and `txRight` three.
- R6: `txCtrl3` and `txCtrl4` stay zero throughout recording. On every playback frame both are loaded with `CTRL_WORD` (default 0x000300).
- R7: A frame edge that lands in the same cycle as the switch from recording to playback is not lost. It becomes the first playback frame and reads the first stored pair.
- R8: After the last playback frame, `done` rises and stays high until reset. Further frames cause no memory access and leave all transmit slots unchanged.
- R9: A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| frameActive | input | 1 | Frame-active flag from the serial port |
| rxLeft | input | DATA_W | Received left sample |
| rxRight | input | DATA_W | Received right sample |
| memWe | output | 1 | Memory write request |
| memRe | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid one cycle after `memRe` |
| txLeft | output | DATA_W | Left transmit slot |
| txRight | output | DATA_W | Right transmit slot |
| txCtrl3 | output | DATA_W | Third transmit slot (control word) |
| txCtrl4 | output | DATA_W | Fourth transmit slot (control word) |
| done | output | 1 | High once playback has finished |

## Verification
Two events can fall in the same cycle: the limit check that turns recording into playback, and the arrival of a fresh frame edge. The bench provokes this by running a whole session with a three-cycle frame period. At that period, the edge after the final record frame lands exactly on the cycle where the limit is first seen. The coincidence is judged correct when the first logged playback pair equals the first recorded pair and the total number of reads is exactly twice the pair count. A second overlap is also exercised: the final right-slot capture coincides with entry into the terminal state. The idle-frame logs must still show that last pair.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic captureRx;
    logic writeLeft;
    logic writeRight;
    logic readLeft;
    logic readRight;
    logic rewind;
  } srpStrobe_t;

  typedef enum logic [2:0] {
    ST_REC_WAIT,
    ST_REC_L,
    ST_REC_R,
    ST_PLAY_WAIT,
    ST_PLAY_L,
    ST_PLAY_R,
    ST_IDLE
  } srpState_t;

endpackage

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter logic [ADDR_W-1:0] START_ADDR = 24'h040000,
  parameter logic [ADDR_W-1:0] LIMIT_ADDR = 24'h050000,
  parameter logic [DATA_W-1:0] CTRL_WORD  = 24'h000300
) (
  input  logic              clk,
  input  logic              rstN,
  input  srpStrobe_t        strb,
  input  logic [DATA_W-1:0] rxLeft,
  input  logic [DATA_W-1:0] rxRight,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] txLeft,
  output logic [DATA_W-1:0] txRight,
  output logic [DATA_W-1:0] txCtrl3,
  output logic [DATA_W-1:0] txCtrl4,
  output logic              pastLimit
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] holdLeft, holdRight;
  logic              pendLeft, pendRight;
  logic              anyAccess;

  assign memWe     = strb.writeLeft | strb.writeRight;
  assign memRe     = strb.readLeft | strb.readRight;
  assign anyAccess = memWe | memRe;
  assign memAddr   = ptr;
  assign memWdata  = strb.writeRight ? holdRight : holdLeft;
  assign pastLimit = (ptr >= LIMIT_ADDR);

  // Address pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= START_ADDR;
    end else if (strb.rewind) begin
      ptr <= START_ADDR;
    end else if (anyAccess) begin
      ptr <= ptr + ADDR_STEP;
    end
  end

  // Received pair latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLeft  <= '0;
      holdRight <= '0;
    end else if (strb.captureRx) begin
      holdLeft  <= rxLeft;
      holdRight <= rxRight;
    end
  end

  // Read return tagging and transmit slots
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLeft  <= 1'b0;
      pendRight <= 1'b0;
      txLeft    <= '0;
      txRight   <= '0;
      txCtrl3   <= '0;
      txCtrl4   <= '0;
    end else begin
      pendLeft  <= strb.readLeft;
      pendRight <= strb.readRight;
      if (pendLeft)  txLeft  <= memRdata;
      if (pendRight) txRight <= memRdata;
      if (strb.readLeft) begin
        txCtrl3 <= CTRL_WORD;
        txCtrl4 <= CTRL_WORD;
      end
    end
  end

  // R3
  pair_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeRight |-> ($past(strb.writeLeft) && (memAddr == ADDR_W'($past(memAddr) + ADDR_STEP))))
    else $error("right sample written without preceding left at previous address");

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyAccess |-> ((memAddr >= START_ADDR) && (memAddr < LIMIT_ADDR)))
    else $error("memory access outside recording window");

  // R5
  read_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readRight |-> $past(strb.readLeft))
    else $error("right read without preceding left read");

  // R9
  access_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe))
    else $error("read and write requested together");

endmodule

// File: rtl/srp_control.sv
module srp_control
  import srp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameActive,
  input  logic       pastLimit,
  output srpStrobe_t strb,
  output logic       done
);

  srpState_t state, stateNext;
  logic      frameSeen;
  logic      frameEdge;

  // Starts high so a flag already high at reset release is not an edge
  assign frameEdge = frameActive & ~frameSeen;
  assign done      = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_REC_WAIT;
      frameSeen <= 1'b1;
    end else begin
      state     <= stateNext;
      frameSeen <= frameActive;
    end
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_REC_WAIT: begin
        if (pastLimit) begin
          strb.rewind = 1'b1;
          stateNext   = frameEdge ? ST_PLAY_L : ST_PLAY_WAIT;
        end else if (frameEdge) begin
          strb.captureRx = 1'b1;
          stateNext      = ST_REC_L;
        end
      end
      ST_REC_L: begin
        strb.writeLeft = 1'b1;
        stateNext      = ST_REC_R;
      end
      ST_REC_R: begin
        strb.writeRight = 1'b1;
        stateNext       = ST_REC_WAIT;
      end
      ST_PLAY_WAIT: begin
        if (pastLimit)      stateNext = ST_IDLE;
        else if (frameEdge) stateNext = ST_PLAY_L;
      end
      ST_PLAY_L: begin
        strb.readLeft = 1'b1;
        stateNext     = ST_PLAY_R;
      end
      ST_PLAY_R: begin
        strb.readRight = 1'b1;
        stateNext      = ST_PLAY_WAIT;
      end
      ST_IDLE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  // R2
  frame_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeLeft || strb.readLeft) |-> ($past(frameActive) && !$past(frameActive, 2)))
    else $error("frame step taken without a low-to-high frame edge");

  // R8
  idle_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done)
    else $error("terminal state left without reset");

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(strb.writeLeft || strb.writeRight || strb.readLeft || strb.readRight))
    else $error("memory strobe while finished");

endmodule

// File: rtl/stereo_rec_play.sv
module stereo_rec_play
  import srp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter logic [ADDR_W-1:0] START_ADDR = 24'h040000,
  parameter logic [ADDR_W-1:0] LIMIT_ADDR = 24'h050000,
  parameter logic [DATA_W-1:0] CTRL_WORD  = 24'h000300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameActive,
  input  logic [DATA_W-1:0] rxLeft,
  input  logic [DATA_W-1:0] rxRight,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] txLeft,
  output logic [DATA_W-1:0] txRight,
  output logic [DATA_W-1:0] txCtrl3,
  output logic [DATA_W-1:0] txCtrl4,
  output logic              done
);

  srpStrobe_t strb;
  logic       pastLimit;

  srp_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameActive (frameActive),
    .pastLimit   (pastLimit),
    .strb        (strb),
    .done        (done)
  );

  srp_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .START_ADDR (START_ADDR),
    .LIMIT_ADDR (LIMIT_ADDR),
    .CTRL_WORD  (CTRL_WORD)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxLeft    (rxLeft),
    .rxRight   (rxRight),
    .memRdata  (memRdata),
    .memWe     (memWe),
    .memRe     (memRe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .txLeft    (txLeft),
    .txRight   (txRight),
    .txCtrl3   (txCtrl3),
    .txCtrl4   (txCtrl4),
    .pastLimit (pastLimit)
  );

endmodule

// File: tb/tb_stereo_rec_play.sv
module tb_stereo_rec_play;

  localparam int          NPAIR = 4;
  localparam logic [23:0] START = 24'h040000;
  localparam logic [23:0] LIMIT = START + 24'(2 * NPAIR);
  localparam logic [23:0] CTRL  = 24'h000300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameActive = 1'b0;
  logic [23:0] rxLeft = '0, rxRight = '0;
  logic        memWe, memRe;
  logic [23:0] memAddr, memWdata;
  logic [23:0] memRdata = '0;
  logic [23:0] txLeft, txRight, txCtrl3, txCtrl4;
  logic        done;

  int checks = 0;
  int failures = 0;
  int curFrame = -1;
  int playBase = 1000;

  stereo_rec_play #(
    .START_ADDR (START),
    .LIMIT_ADDR (LIMIT)
  ) dut (
    .clk(clk), .rstN(rstN), .frameActive(frameActive),
    .rxLeft(rxLeft), .rxRight(rxRight),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata),
    .txLeft(txLeft), .txRight(txRight), .txCtrl3(txCtrl3), .txCtrl4(txCtrl4),
    .done(done)
  );

  always #4 clk = ~clk;

  // Memory model with one-cycle read latency and access-order tracking
  logic [23:0] memModel [0:15];
  int wrCount, rdCount, protoErr;

  always @(posedge clk) begin
    if (!rstN) begin
      wrCount  <= 0;
      rdCount  <= 0;
      protoErr <= 0;
    end else begin
      if (memWe && memRe) protoErr <= protoErr + 1;
      if (memWe) begin
        if (memAddr != START + 24'(wrCount)) protoErr <= protoErr + 1;
        else memModel[4'(memAddr - START)] <= memWdata;
        wrCount <= wrCount + 1;
      end
      if (memRe) begin
        if (memAddr != START + 24'(rdCount)) protoErr <= protoErr + 1;
        memRdata <= memModel[4'(memAddr - START)];
        rdCount  <= rdCount + 1;
      end
    end
  end

  // Frame-edge history from the bench's own stimulus, tagged by frame number
  logic       fPrev = 1'b1;
  logic [3:0] riseV = '0;
  int         tagPipe [0:3];
  logic [23:0] logL [0:15];
  logic [23:0] logR [0:15];
  logic [23:0] logC3 [0:15];
  logic [23:0] logC4 [0:15];

  always @(posedge clk) begin
    fPrev      <= frameActive;
    riseV      <= {riseV[2:0], frameActive & ~fPrev};
    tagPipe[0] <= curFrame;
    tagPipe[1] <= tagPipe[0];
    tagPipe[2] <= tagPipe[1];
    tagPipe[3] <= tagPipe[2];
  end

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin
        logL[i] <= '0; logR[i] <= '0; logC3[i] <= '0; logC4[i] <= '0;
      end
    end else if (riseV[3] && tagPipe[3] >= playBase && tagPipe[3] - playBase < 16) begin
      logL[tagPipe[3] - playBase]  <= txLeft;
      logR[tagPipe[3] - playBase]  <= txRight;
      logC3[tagPipe[3] - playBase] <= txCtrl3;
      logC4[tagPipe[3] - playBase] <= txCtrl4;
    end
  end

  function automatic logic [23:0] leftOf(int seed, int k);
    return 24'(seed * 7919 + k * 24'h010305);
  endfunction

  function automatic logic [23:0] rightOf(int seed, int k);
    return 24'(seed * 131 + k * 24'h020401 + 24'h300000);
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic resetDut(logic highDuring);
    @(negedge clk);
    rstN = 1'b0;
    frameActive = highDuring;
    curFrame = -1;
    playBase = 1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(int h, int l, logic [23:0] lv, logic [23:0] rv);
    rxLeft = lv;
    rxRight = rv;
    curFrame++;
    frameActive = 1'b1;
    repeat (h) @(posedge clk);
    @(negedge clk);
    frameActive = 1'b0;
    repeat (l) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    resetDut(1'b0);
    check("R1 done", 24'(done), 24'd0);
    check("R1 txLeft", txLeft, 24'd0);
    check("R1 txRight", txRight, 24'd0);
    check("R1 txCtrl3", txCtrl3, 24'd0);
    check("R1 txCtrl4", txCtrl4, 24'd0);
    check("R1 no access", 24'(memWe | memRe), 24'd0);
    check("R1 write count", 24'(wrCount), 24'd0);
  endtask

  task automatic testHeldHigh();
    resetDut(1'b1);
    repeat (6) @(negedge clk);
    check("R2 high through reset gives no step", 24'(wrCount), 24'd0);
    frameActive = 1'b0;
    @(posedge clk);
    @(negedge clk);
    frame(3, 4, 24'h123456, 24'h654321);
    check("R2 first edge takes one step", 24'(wrCount), 24'd2);
    check("R3 left word stored first", memModel[0], 24'h123456);
    check("R3 right word stored next", memModel[1], 24'h654321);
    frame(9, 2, 24'h0A0B0C, 24'h0C0B0A);
    check("R2 long high gives one step", 24'(wrCount), 24'd4);
  endtask

  task automatic runSession(int h, int l, int seed, logic fast);
    resetDut(1'b0);
    playBase = NPAIR;
    for (int k = 0; k < NPAIR; k++) frame(h, l, leftOf(seed, k), rightOf(seed, k));
    check("R3 writes after record", 24'(wrCount), 24'(2 * NPAIR));
    for (int k = 0; k < NPAIR; k++) begin
      check("R3 stored left", memModel[2 * k], leftOf(seed, k));
      check("R3 stored right", memModel[2 * k + 1], rightOf(seed, k));
    end
    check("R6 ctrl slot zero in record", txCtrl3, 24'd0);
    check("R8 done low in record", 24'(done), 24'd0);
    for (int k = 0; k < NPAIR; k++) frame(h, l, 24'hFFFFFF, 24'hEEEEEE);
    for (int k = 0; k < 3; k++) frame(h, l, 24'h111111, 24'h222222);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 no writes after limit", 24'(wrCount), 24'(2 * NPAIR));
    check("R4 reads cover window once", 24'(rdCount), 24'(2 * NPAIR));
    check("R9 access order and exclusivity", 24'(protoErr), 24'd0);
    for (int k = 0; k < NPAIR; k++) begin
      if (fast && k == 0) begin
        check("R7 first pair left on coincident edge", logL[k], leftOf(seed, k));
        check("R7 first pair right on coincident edge", logR[k], rightOf(seed, k));
      end else begin
        check("R5 playback left", logL[k], leftOf(seed, k));
        check("R5 playback right", logR[k], rightOf(seed, k));
      end
      check("R6 ctrl slot 3", logC3[k], CTRL);
      check("R6 ctrl slot 4", logC4[k], CTRL);
    end
    for (int k = NPAIR; k < NPAIR + 3; k++) begin
      check("R8 idle left unchanged", logL[k], leftOf(seed, NPAIR - 1));
      check("R8 idle right unchanged", logR[k], rightOf(seed, NPAIR - 1));
    end
    check("R8 done high", 24'(done), 24'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testHeldHigh();
    runSession(3, 4, 17, 1'b0);
    runSession(2, 1, 42, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule